// File: doc/BRIEF.md
# Load Extend and Insert Merge Unit

This unit sits at the end of the load path, after the memory has answered. Each cycle it can take a 5-bit memory-reference opcode, an aligned 64-bit memory word, a byte offset into that word and the current contents of the destination register. It decodes the opcode into operand size (8, 16, 32 or 64 bits), fill mode and direction. It then selects the operand from the word and builds the new register value.

A sign-extending load copies the operand's top bit into every higher register bit. An unsigned load clears every higher bit. An insert writes the operand into the low bits and keeps the upper bits of the old register. Floating-point loads are decoded and their memory word is passed through unchanged. Stores, misaligned integer accesses and illegal opcodes never write the register. Address generation happens elsewhere.

Results are registered once by default, so every output belongs to the request presented one clock earlier.

Top module: `ldmerge_unit`

## Requirements
- R1: The byte offset `mem_off` picks the operand from `mem_word` in little-endian lane order: the operand's least significant byte is `mem_word[8*mem_off+7 : 8*mem_off]`.
- R2: The load opcodes 01000 (byte), 01100 (half), 11000 (word) and 11100 (long) sign-extend the operand as a two's complement value to 64 bits.
- R3: The unsigned opcodes 01011 (byte), 01111 (half) and 11011 (word) zero every result bit above the operand.
- R4: The insert opcodes 01010 (byte), 01110 (half) and 11010 (word) place the operand in the low bits of the result, and every bit above it equals `old_reg`.
- R5: The integer store opcodes 01001, 01101, 11001 and 11101 raise `is_store`, hold `reg_we` low and return `old_reg` on `result`.
- R6: The floating-point load opcodes 00100, 00110, 10100 and 10110 raise `reg_we` and return `mem_word` unchanged for any offset, with `misalign` low. The store opcodes 00101, 00111, 10101 and 10111 raise `is_store` with `reg_we` low.
- R7: An integer access whose offset is not a multiple of its operand size in bytes raises `misalign`. It holds `reg_we` low and returns `old_reg`.
- R8: Every other opcode (00000 to 00011, 10000 to 10011, 11110, 11111) raises `illegal`. It holds `reg_we` and `is_store` low and returns `old_reg`.
- R9: `out_valid` follows `in_valid` one clock later. While `out_valid` is low, `reg_we`, `is_store`, `misalign` and `illegal` are all low.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 5 | Memory-reference opcode |
| mem_off | input | 3 | Byte offset of the operand inside `mem_word` |
| mem_word | input | 64 | Aligned memory read data |
| old_reg | input | 64 | Current destination register value |
| out_valid | output | 1 | Result present |
| result | output | 64 | New register value |
| reg_we | output | 1 | Register write enable |
| is_store | output | 1 | Request is a store |
| misalign | output | 1 | Operand offset not aligned to its size |
| illegal | output | 1 | Opcode not in the map |

## Verification
Each request passes through exactly one register stage. All of its results (`result`, `reg_we`, `is_store`, `misalign`, `illegal`) and its `out_valid` therefore appear together after the first rising edge following the request. The bench changes inputs on the falling edge and waits for the next rising edge. It samples one time unit after that edge, so each check reads the response to exactly the request it just applied. A cycle with `in_valid` low is checked the same way, to confirm that the flags drop with `out_valid`.

// File: rtl/lxm_pkg.sv
`timescale 1ns/1ps
package lxm_pkg;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_L = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      MD_SIGN = 2'd0,
      MD_ZERO = 2'd1,
      MD_INS  = 2'd2
   } mode_e;

   typedef struct packed {
      logic  legal;
      logic  fp;
      logic  store;
      size_e size;
      mode_e mode;
   } dec_t;

endpackage

// File: rtl/lxm_decode.sv
`timescale 1ns/1ps
module lxm_decode
   import lxm_pkg::*;
#(
   parameter int OPC_W = 5
) (
   input  logic [OPC_W-1:0] opc,
   output dec_t             dec
);

   if (OPC_W != 5) begin : g_bad_opc
      $error("lxm_decode: OPC_W must be 5");
   end

   always_comb begin
      dec       = '0;
      dec.size  = SZ_B;
      dec.mode  = MD_SIGN;
      case (opc[4:3])
         2'b01: begin
            dec.legal = 1'b1;
            if (opc[2]) dec.size = SZ_H;
            else        dec.size = SZ_B;
         end
         2'b11: begin
            if (!opc[2]) begin
               dec.legal = 1'b1;
               dec.size  = SZ_W;
            end else if (!opc[1]) begin
               dec.legal = 1'b1;
               dec.size  = SZ_L;
            end
         end
         default: begin
            if (opc[2]) begin
               dec.legal = 1'b1;
               dec.fp    = 1'b1;
               dec.size  = SZ_L;
            end
         end
      endcase

      if (dec.legal && dec.fp) begin
         dec.store = opc[0];
      end else if (dec.legal) begin
         dec.store = (opc[1:0] == 2'b01);
         case (opc[1:0])
            2'b10:   dec.mode = MD_INS;
            2'b11:   dec.mode = MD_ZERO;
            default: dec.mode = MD_SIGN;
         endcase
      end
   end

endmodule

// File: rtl/lxm_extract.sv
`timescale 1ns/1ps
module lxm_extract
   import lxm_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] mem,
   input  logic [OFF_W-1:0]  off,
   input  size_e             size,
   output logic [DATA_W-1:0] shifted,
   output logic              misal
);

   logic [OFF_W-1:0] amask;

   always_comb begin
      shifted = mem >> {off, 3'b000};
      case (size)
         SZ_B:    amask = '0;
         SZ_H:    amask = OFF_W'(1);
         SZ_W:    amask = OFF_W'(3);
         default: amask = OFF_W'(7);
      endcase
      misal = |(off & amask);
   end

endmodule

// File: rtl/lxm_merge.sv
`timescale 1ns/1ps
module lxm_merge
   import lxm_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] field,
   input  logic [DATA_W-1:0] old,
   input  size_e             size,
   input  mode_e             mode,
   output logic [DATA_W-1:0] result
);

   logic [LANES-1:0] keep;
   logic             sgn;

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         keep[i] = (i < (1 << int'(size)));
      end
      case (size)
         SZ_B:    sgn = field[7];
         SZ_H:    sgn = field[15];
         SZ_W:    sgn = field[31];
         default: sgn = field[DATA_W-1];
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] fill;
      always_comb begin
         case (mode)
            MD_INS:  fill = old[8*g +: 8];
            MD_ZERO: fill = 8'h00;
            default: fill = {8{sgn}};
         endcase
      end
      assign result[8*g +: 8] = keep[g] ? field[8*g +: 8] : fill;
   end

   always_comb begin
      if (mode == MD_ZERO && size == SZ_B) begin
         p_zero_byte_r3: assert (result[DATA_W-1:8] == '0);
      end
      if (mode == MD_INS && size == SZ_H) begin
         p_ins_half_r4: assert (result[DATA_W-1:16] == old[DATA_W-1:16]);
      end
      if (mode == MD_SIGN && size == SZ_W) begin
         p_sign_word_r2: assert (result[DATA_W-1:32] == {(DATA_W-32){field[31]}});
      end
   end

endmodule

// File: rtl/ldmerge_unit.sv
`timescale 1ns/1ps
module ldmerge_unit
   import lxm_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter int OPC_W        = 5,
   parameter bit REGISTER_OUT = 1'b1,
   localparam int OFF_W = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [OFF_W-1:0]  mem_off,
   input  logic [DATA_W-1:0] mem_word,
   input  logic [DATA_W-1:0] old_reg,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              reg_we,
   output logic              is_store,
   output logic              misalign,
   output logic              illegal
);

   if (DATA_W != 64) begin : g_bad_width
      $error("ldmerge_unit: DATA_W must be 64");
   end

   dec_t              dec;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] merged;
   logic              misal;

   lxm_decode #(.OPC_W(OPC_W)) u_dec (
      .opc (opcode),
      .dec (dec)
   );

   lxm_extract #(.DATA_W(DATA_W)) u_ext (
      .mem     (mem_word),
      .off     (mem_off),
      .size    (dec.size),
      .shifted (shifted),
      .misal   (misal)
   );

   lxm_merge #(.DATA_W(DATA_W)) u_mrg (
      .field  (shifted),
      .old    (old_reg),
      .size   (dec.size),
      .mode   (dec.mode),
      .result (merged)
   );

   logic              bad_align;
   logic              n_we;
   logic              n_store;
   logic              n_mis;
   logic              n_ill;
   logic [DATA_W-1:0] n_res;

   always_comb begin
      bad_align = dec.legal && !dec.fp && misal;
      n_we      = in_valid && dec.legal && !dec.store && !bad_align;
      n_store   = in_valid && dec.legal && dec.store;
      n_mis     = in_valid && bad_align;
      n_ill     = in_valid && !dec.legal;
      if (!n_we)       n_res = old_reg;
      else if (dec.fp) n_res = mem_word;
      else             n_res = merged;
   end

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            reg_we    <= 1'b0;
            is_store  <= 1'b0;
            misalign  <= 1'b0;
            illegal   <= 1'b0;
         end else begin
            out_valid <= in_valid;
            result    <= n_res;
            reg_we    <= n_we;
            is_store  <= n_store;
            misalign  <= n_mis;
            illegal   <= n_ill;
         end
      end

      p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = n_res;
      assign reg_we    = n_we;
      assign is_store  = n_store;
      assign misalign  = n_mis;
      assign illegal   = n_ill;
   end

   p_we_vs_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && is_store));

   p_mis_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> !reg_we);

   p_ill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!reg_we && !is_store && !misalign));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!reg_we && !is_store && !misalign && !illegal));

   p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal, reg_we, is_store}));

endmodule

// File: tb/sim_ldmerge_unit.sv
`timescale 1ns/1ps
module sim_ldmerge_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  opcode = '0;
   logic [2:0]  mem_off = '0;
   logic [63:0] mem_word = '0;
   logic [63:0] old_reg = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        reg_we;
   logic        is_store;
   logic        misalign;
   logic        illegal;

   int checks = 0;
   int errors = 0;

   localparam logic [63:0] MEM = 64'hF1E2_D3C4_85A6_9778;
   localparam logic [63:0] OLD = 64'h0123_4567_89AB_CDEF;

   always #5 clk = ~clk;

   ldmerge_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .mem_off(mem_off), .mem_word(mem_word), .old_reg(old_reg),
      .out_valid(out_valid), .result(result), .reg_we(reg_we),
      .is_store(is_store), .misalign(misalign), .illegal(illegal)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // flags packed as {out_valid, reg_we, is_store, misalign, illegal}
   task automatic issue(input logic v, input logic [4:0] op, input logic [2:0] off,
                        input logic [63:0] mw, input logic [63:0] og);
      @(negedge clk);
      in_valid = v; opcode = op; mem_off = off; mem_word = mw; old_reg = og;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input string req, input logic [63:0] res, input logic [4:0] flags);
      chk(req, result, res);
      chk(req, {59'd0, out_valid, reg_we, is_store, misalign, illegal}, {59'd0, flags});
   endtask

   task automatic t_reset;
      #1;
      expect_out("R10", 64'd0, 5'b00000);
   endtask

   task automatic t_lanes;
      for (int k = 0; k < 8; k++) begin
         logic [7:0] b;
         b = MEM[8*k +: 8];
         issue(1'b1, 5'b01000, 3'(k), MEM, OLD);
         expect_out("R1", {{56{b[7]}}, b}, 5'b11000);
      end
   endtask

   task automatic t_sign;
      issue(1'b1, 5'b01000, 3'd0, MEM, OLD);
      expect_out("R2", 64'h0000_0000_0000_0078, 5'b11000);
      issue(1'b1, 5'b01100, 3'd0, MEM, OLD);
      expect_out("R2", 64'hFFFF_FFFF_FFFF_9778, 5'b11000);
      issue(1'b1, 5'b01100, 3'd4, MEM, OLD);
      expect_out("R2", 64'hFFFF_FFFF_FFFF_D3C4, 5'b11000);
      issue(1'b1, 5'b11000, 3'd0, MEM, OLD);
      expect_out("R2", 64'hFFFF_FFFF_85A6_9778, 5'b11000);
      issue(1'b1, 5'b11000, 3'd4, 64'h0000_0000_7000_0000 << 32, OLD);
      expect_out("R2", 64'h0000_0000_7000_0000, 5'b11000);
      issue(1'b1, 5'b11100, 3'd0, MEM, OLD);
      expect_out("R2", MEM, 5'b11000);
   endtask

   task automatic t_zero;
      issue(1'b1, 5'b01011, 3'd1, MEM, OLD);
      expect_out("R3", 64'h0000_0000_0000_0097, 5'b11000);
      issue(1'b1, 5'b01111, 3'd6, MEM, OLD);
      expect_out("R3", 64'h0000_0000_0000_F1E2, 5'b11000);
      issue(1'b1, 5'b11011, 3'd0, MEM, OLD);
      expect_out("R3", 64'h0000_0000_85A6_9778, 5'b11000);
   endtask

   task automatic t_insert;
      issue(1'b1, 5'b01010, 3'd7, MEM, OLD);
      expect_out("R4", 64'h0123_4567_89AB_CDF1, 5'b11000);
      issue(1'b1, 5'b01110, 3'd2, MEM, OLD);
      expect_out("R4", 64'h0123_4567_89AB_85A6, 5'b11000);
      issue(1'b1, 5'b11010, 3'd4, MEM, OLD);
      expect_out("R4", 64'h0123_4567_F1E2_D3C4, 5'b11000);
   endtask

   task automatic t_store;
      issue(1'b1, 5'b01001, 3'd3, MEM, OLD);
      expect_out("R5", OLD, 5'b10100);
      issue(1'b1, 5'b01101, 3'd2, MEM, OLD);
      expect_out("R5", OLD, 5'b10100);
      issue(1'b1, 5'b11001, 3'd0, MEM, OLD);
      expect_out("R5", OLD, 5'b10100);
      issue(1'b1, 5'b11101, 3'd0, MEM, OLD);
      expect_out("R5", OLD, 5'b10100);
   endtask

   task automatic t_fp;
      issue(1'b1, 5'b10100, 3'd3, MEM, OLD);
      expect_out("R6", MEM, 5'b11000);
      issue(1'b1, 5'b00100, 3'd5, MEM, OLD);
      expect_out("R6", MEM, 5'b11000);
      issue(1'b1, 5'b00110, 3'd1, MEM, OLD);
      expect_out("R6", MEM, 5'b11000);
      issue(1'b1, 5'b10110, 3'd7, MEM, OLD);
      expect_out("R6", MEM, 5'b11000);
      issue(1'b1, 5'b00111, 3'd0, MEM, OLD);
      expect_out("R6", OLD, 5'b10100);
      issue(1'b1, 5'b10101, 3'd0, MEM, OLD);
      expect_out("R6", OLD, 5'b10100);
   endtask

   task automatic t_misalign;
      issue(1'b1, 5'b01100, 3'd1, MEM, OLD);
      expect_out("R7", OLD, 5'b10010);
      issue(1'b1, 5'b11000, 3'd2, MEM, OLD);
      expect_out("R7", OLD, 5'b10010);
      issue(1'b1, 5'b11100, 3'd4, MEM, OLD);
      expect_out("R7", OLD, 5'b10010);
      issue(1'b1, 5'b11001, 3'd6, MEM, OLD);
      expect_out("R7", OLD, 5'b10110);
   endtask

   task automatic t_illegal;
      issue(1'b1, 5'b00000, 3'd0, MEM, OLD);
      expect_out("R8", OLD, 5'b10001);
      issue(1'b1, 5'b10010, 3'd0, MEM, OLD);
      expect_out("R8", OLD, 5'b10001);
      issue(1'b1, 5'b11110, 3'd0, MEM, OLD);
      expect_out("R8", OLD, 5'b10001);
      issue(1'b1, 5'b11111, 3'd0, MEM, OLD);
      expect_out("R8", OLD, 5'b10001);
   endtask

   task automatic t_idle;
      issue(1'b0, 5'b11001, 3'd0, MEM, OLD);
      expect_out("R9", OLD, 5'b00000);
      issue(1'b0, 5'b11110, 3'd1, MEM, OLD);
      expect_out("R9", OLD, 5'b00000);
      issue(1'b1, 5'b11100, 3'd0, MEM, OLD);
      expect_out("R9", MEM, 5'b11000);
   endtask

   initial begin
      t_reset();
      #22;
      rst_n = 1'b1;
      t_lanes();
      t_sign();
      t_zero();
      t_insert();
      t_store();
      t_fp();
      t_misalign();
      t_illegal();
      t_idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule